// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of which reset sources have fired since software last acknowledged them, so that start-up code can tell a cold power-up from a pin reset, a watchdog reset or a supply dip. Four cause bits sit in the low end of a 32-bit register. Software reads the register on `rdata_o` at any time, because the read is a plain combinational view of the stored bits. Software writes through `wr_en_i`/`wdata_i`, and each 1 written acknowledges (clears) the matching bit.

The inputs are synchronous flags. The supply is described by two levels: `below_bod_i` is high while the supply is under the brown-out trip level, and `below_por_i` is high while it is under the power-on threshold. The block treats `below_por_i` as power-on reset. It also serves as the only initialising condition of the block's own flops, so the block has no separate reset pin. Every update takes effect on the rising clock edge that samples the inputs. There is no stream data here, so every pin is a plain level with no handshake.

Top module: `rst_cause_reg`

## Requirements
- R1: Bit 0 is power-on, bit 1 is external pin, bit 2 is watchdog and bit 3 is brown-out. Bits 31:4 always read 0, and writing to them changes nothing.
- R2: A write with `wr_en_i` high clears every cause bit whose `wdata_i` bit is 1 on that clock edge. Bits written 0 keep their value, and any of the four bits can be cleared this way.
- R3: On each edge where `below_por_i` is high, the register becomes 0x1.
- R4: `ext_rst_i` high sets bit 1 on that edge. Bit 1 then stays set until a software clear or power-on.
- R5: `wdt_timeout_i` sets bit 2 only when `wdt_rst_en_i` is 1 in the same cycle. A timeout with the enable at 0 leaves bit 2 unchanged.
- R6: When a hardware set and a software clear hit the same bit in one cycle, the bit ends up set.
- R7: No source other than power-on ever sets bit 0, and only a software write clears it.
- R8: A dip below the brown-out level that recovers without reaching the power-on threshold sets bit 3 on the edge where `below_bod_i` is first sampled low. Bit 3 is not set while the supply is still low.
- R9: A dip that goes on down to the power-on threshold leaves bit 3 at 0, because power-on clears it.
- R10: After power-on, bit 3 becomes set on the first edge that samples both supply flags low.
- R11: A pin reset still held when power-on releases sets bit 1 on the first edge after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| below_por_i | input | 1 | Supply under the power-on threshold; acts as power-on reset |
| below_bod_i | input | 1 | Supply under the brown-out trip level |
| ext_rst_i | input | 1 | External reset pin is active |
| wdt_timeout_i | input | 1 | Watchdog timeout event |
| wdt_rst_en_i | input | 1 | Watchdog timeouts are allowed to cause resets |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| wdata_i | input | 32 | Write data; a 1 clears the cause bit at that position |
| rdata_o | output | 32 | Current register contents |

## Verification
Every cause bit is visible on `rdata_o` as soon as the edge that updated it has passed. A wrong stored bit therefore appears on the read port within one cycle of the stimulus that should have produced it. Faults in the brown-out tracker stay hidden until the supply flags move. For that reason the stimulus walks recover-only dips, dips into power-on and power-up ramps, and checks the exact cycle on which bit 3 appears. The set-versus-clear ordering and the held-through-power-on case both come down to a single edge, so each one is checked on the cycle right after its stimulus.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int DATA_W  = 32;
  localparam int CAUSE_N = 4;
  localparam int BIT_POR = 0;
  localparam int BIT_EXT = 1;
  localparam int BIT_WDT = 2;
  localparam int BIT_BOD = 3;
  typedef logic [CAUSE_N-1:0] cause_t;
endpackage

// File: rtl/rcs_sticky.sv
// One cause flag: wiped by power-on to WIPE_VAL, set by hardware, cleared by software.
module rcs_sticky #(
  parameter bit WIPE_VAL = 1'b0
) (
  input  logic clk,
  input  logic wipe_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk) begin
    if (wipe_i)      q <= WIPE_VAL;
    else if (set_i)  q <= 1'b1;
    else if (clr_i)  q <= 1'b0;
  end

  assign q_o = q;

  // R6: a set beats a simultaneous clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (wipe_i)
    set_i |=> q_o);
  // R2: a clear with no set empties the flag
  p_clear_r2: assert property (@(posedge clk) disable iff (wipe_i)
    (clr_i && !set_i) |=> !q_o);
  // R4: with no set and no clear the flag holds its value
  p_hold_r4: assert property (@(posedge clk) disable iff (wipe_i)
    (!clr_i && !set_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/rcs_bod_track.sv
// Remembers that the supply was low and reports the cycle it is back above the trip level.
module rcs_bod_track (
  input  logic clk,
  input  logic below_por_i,
  input  logic below_bod_i,
  output logic recover_o
);
  logic low_seen_q;

  always_ff @(posedge clk) begin
    low_seen_q <= below_bod_i | below_por_i;
  end

  assign recover_o = low_seen_q & ~below_bod_i & ~below_por_i;

  // R8: a recovery is reported for a single cycle only
  p_recover_pulse_r8: assert property (@(posedge clk) disable iff (below_por_i)
    recover_o |=> !recover_o);
  // R8: no recovery is reported while the supply is still under the trip level
  p_no_early_r8: assert property (@(posedge clk) disable iff (below_por_i)
    below_bod_i |-> !recover_o);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcs_pkg::*;
(
  input  logic              clk,
  input  logic              below_por_i,
  input  logic              below_bod_i,
  input  logic              ext_rst_i,
  input  logic              wdt_timeout_i,
  input  logic              wdt_rst_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int RSV_W = DATA_W - CAUSE_N;

  cause_t set_v;
  cause_t clr_v;
  cause_t cause_q;
  logic   bod_recover;
  logic   rsv_written;

  rcs_bod_track u_bod (
    .clk         (clk),
    .below_por_i (below_por_i),
    .below_bod_i (below_bod_i),
    .recover_o   (bod_recover)
  );

  always_comb begin
    set_v          = '0;
    set_v[BIT_EXT] = ext_rst_i;
    set_v[BIT_WDT] = wdt_timeout_i & wdt_rst_en_i;
    set_v[BIT_BOD] = bod_recover;
    clr_v          = wr_en_i ? wdata_i[CAUSE_N-1:0] : '0;
  end

  assign rsv_written = wr_en_i & (|wdata_i[DATA_W-1:CAUSE_N]);

  for (genvar i = 0; i < CAUSE_N; i++) begin : g_cause
    rcs_sticky #(.WIPE_VAL(i == BIT_POR)) u_bit (
      .clk    (clk),
      .wipe_i (below_por_i),
      .set_i  (set_v[i]),
      .clr_i  (clr_v[i]),
      .q_o    (cause_q[i])
    );
  end

  assign rdata_o = {{RSV_W{1'b0}}, cause_q};

  // R5: a timeout with the enable low never sets the watchdog bit
  p_wdt_gated_r5: assert property (@(posedge clk) disable iff (below_por_i)
    (wdt_timeout_i && !wdt_rst_en_i && !rdata_o[BIT_WDT]) |=> !rdata_o[BIT_WDT]);
  // R7: the power-on bit only falls after a software write of 1 to it
  p_por_sw_only_r7: assert property (@(posedge clk) disable iff (below_por_i)
    $fell(rdata_o[BIT_POR]) |-> $past(wr_en_i && wdata_i[BIT_POR]));
  // R1: a write holding only reserved ones, with no hardware event, changes nothing
  p_reserved_ignored_r1: assert property (@(posedge clk) disable iff (below_por_i)
    (rsv_written && wdata_i[CAUSE_N-1:0] == '0 && set_v == '0) |=> $stable(rdata_o));
  // R4: the pin input shows in bit 1 on the next cycle
  p_ext_set_r4: assert property (@(posedge clk) disable iff (below_por_i)
    ext_rst_i |=> rdata_o[BIT_EXT]);
endmodule

// File: tb/test_rst_cause_reg.sv
module test_rst_cause_reg;
  logic        clk = 1'b0;
  logic        below_por = 1'b1;
  logic        below_bod = 1'b1;
  logic        ext_rst = 1'b0;
  logic        wdt_to = 1'b0;
  logic        wdt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  rst_cause_reg i_rst_cause_reg (
    .clk           (clk),
    .below_por_i   (below_por),
    .below_bod_i   (below_bod),
    .ext_rst_i     (ext_rst),
    .wdt_timeout_i (wdt_to),
    .wdt_rst_en_i  (wdt_en),
    .wr_en_i       (wr_en),
    .wdata_i       (wdata),
    .rdata_o       (rdata)
  );

  // Row: {req[3:0], por, bod, ext, wdt, en, wr, wd[3:0], exp[3:0]}
  localparam int NROW = 28;
  localparam logic [17:0] ROWS [NROW] = '{
    {4'd10, 6'b010000, 4'h0, 4'h1},  // R10 still below brown-out
    {4'd10, 6'b000000, 4'h0, 4'h9},  // R10 both flags low -> bod set
    {4'd4,  6'b000000, 4'h0, 4'h9},  // R4 idle hold
    {4'd2,  6'b000001, 4'hF, 4'h0},  // R2 clear all
    {4'd4,  6'b001000, 4'h0, 4'h2},  // R4 pin sets bit1
    {4'd4,  6'b000000, 4'h0, 4'h2},  // R4 sticky
    {4'd5,  6'b000100, 4'h0, 4'h2},  // R5 gated timeout
    {4'd5,  6'b000110, 4'h0, 4'h6},  // R5 enabled timeout
    {4'd2,  6'b000001, 4'h2, 4'h4},  // R2 selective clear
    {4'd6,  6'b001001, 4'h2, 4'h6},  // R6 pin beats clear
    {4'd6,  6'b000111, 4'h4, 4'h6},  // R6 watchdog beats clear
    {4'd2,  6'b000001, 4'h0, 4'h6},  // R2 zero write no effect
    {4'd2,  6'b000001, 4'h6, 4'h0},  // R2 clear two
    {4'd8,  6'b010000, 4'h0, 4'h0},  // R8 dip
    {4'd8,  6'b010000, 4'h0, 4'h0},  // R8 still low, no set yet
    {4'd8,  6'b000000, 4'h0, 4'h8},  // R8 recovery sets bit3
    {4'd7,  6'b001110, 4'h0, 4'hE},  // R7 bit0 untouched by sources
    {4'd3,  6'b111000, 4'h0, 4'h1},  // R3 power-on wipes
    {4'd11, 6'b011000, 4'h0, 4'h3},  // R11 pin held past release
    {4'd10, 6'b000000, 4'h0, 4'hB},  // R10 ramp up done
    {4'd2,  6'b000001, 4'h8, 4'h3},  // R2 clear bod
    {4'd2,  6'b000001, 4'h1, 4'h2},  // R2 clear por bit
    {4'd5,  6'b000101, 4'h0, 4'h2},  // R5 gated with write 0
    {4'd8,  6'b010000, 4'h0, 4'h2},  // R8 dip
    {4'd8,  6'b000000, 4'h0, 4'hA},  // R8 recover
    {4'd9,  6'b010000, 4'h0, 4'hA},  // R9 dip again
    {4'd9,  6'b110000, 4'h0, 4'h1},  // R9 reaches power-on, bit3 cleared
    {4'd10, 6'b000000, 4'h0, 4'h9}   // R10 ramp up
  };

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (rdata !== exp) begin
      n_err++;
      $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
    end
  endtask

  task automatic drive_idle();
    below_por = 1'b0; below_bod = 1'b0; ext_rst = 1'b0;
    wdt_to = 1'b0; wdt_en = 1'b0; wr_en = 1'b0; wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R3", 32'h1);  // reset state

    for (int r = 0; r < NROW; r++) begin
      below_por = ROWS[r][13];
      below_bod = ROWS[r][12];
      ext_rst   = ROWS[r][11];
      wdt_to    = ROWS[r][10];
      wdt_en    = ROWS[r][9];
      wr_en     = ROWS[r][8];
      wdata     = {28'h0, ROWS[r][7:4]};
      @(negedge clk);
      check($sformatf("R%0d row %0d", ROWS[r][17:14], r), {28'h0, ROWS[r][3:0]});
    end

    // R1: reserved-only write changes nothing; upper bits read 0
    drive_idle();
    wr_en = 1'b1; wdata = 32'hFFFF_FFF0;
    @(negedge clk);
    check("R1 reserved write", 32'h9);
    // R1: full-ones write clears only the cause bits
    wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R1 all ones", 32'h0);
    // R7: bit0 stays 0 under every non-power-on source
    drive_idle();
    ext_rst = 1'b1; wdt_to = 1'b1; wdt_en = 1'b1; below_bod = 1'b1;
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    check("R7 no por from others", 32'hE);
    // R3: long power-on hold keeps 0x1 even with all sources active
    below_por = 1'b1; below_bod = 1'b1; ext_rst = 1'b1; wdt_to = 1'b1; wdt_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 held", 32'h1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: rdata=%h expected=finish", rdata);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule